// File: doc/BRIEF.md
# Correlator Loopback Test Signal Generator

This block produces a synthetic two-bit sample stream, a sign bit and a magnitude bit, that looks enough like a received satellite signal to be fed back into correlator channels for loopback testing. It draws the top carrier phase bits, the spreading-code chip and the 1 ms code-epoch tick from one of two tracking channels. A fixed weight converter turns the carrier phase into sign and magnitude. The sign is then modulated by the code chip and by a slow alternating data bit, and it can be flipped by a pseudo-random noise bit whose rate is set by an 8-bit duty value.

Both outputs are registered once, so the internal channel feed and the external test pins change on the same edge. A single enable gates the whole block. While it is disabled, both outputs read zero and the data-bit and noise state return to their start values.

Top module: `stg_top`

## Requirements
- R1: While `en_i` is 0, both outputs are 0 after the next clock edge. After reset, both outputs are 0.
- R2: With `src_sel_i` = 0, the phase, chip and epoch inputs of channel 1 drive the generator. With `src_sel_i` = 1, those of channel 2 drive it, and the inputs of the other channel have no effect.
- R3: The weight sign equals bit 4 of the 5-bit selected phase. The weight magnitude is 1 for phase values 11, 12 to 15, 16 to 19 and 20 (binary 01011, 011xx, 100xx, 10100), and 0 for the other 22 values.
- R4: When enabled, `sign_o` = weight sign XOR selected chip XOR data bit XOR noise bit, and `mag_o` = weight magnitude.
- R5: The data bit starts at 0. It inverts on every 20th selected epoch tick counted since it was cleared, and the output formed in the same cycle as that tick still uses the old value.
- R6: Asserting `chan_rst_i`, or holding `en_i` low, clears the data bit and the epoch count to 0 and reloads the noise register with 1.
- R7: The noise register is 15 bits wide. In each enabled cycle without `chan_rst_i`, it shifts toward its MSB and takes bit14 XOR bit13 into bit 0. The noise bit is 1 when the register's low 8 bits, read as an unsigned number, are below `duty_i`.
- R8: With `duty_i` = 0, the noise bit is never asserted, and the output is the clean modulated signal.
- R9: Each output reflects the inputs sampled one clock earlier, through exactly one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Generator enable |
| src_sel_i | input | 1 | Source channel select: 0 selects channel 1, 1 selects channel 2 |
| chan_rst_i | input | 1 | Common channel reset; restarts the data bit and the noise |
| duty_i | input | 8 | Noise duty threshold; 0 turns noise off |
| ch1_phase_i | input | 5 | Channel 1 carrier phase, top bits |
| ch1_chip_i | input | 1 | Channel 1 code chip |
| ch1_epoch_i | input | 1 | Channel 1 code-epoch tick |
| ch2_phase_i | input | 5 | Channel 2 carrier phase, top bits |
| ch2_chip_i | input | 1 | Channel 2 code chip |
| ch2_epoch_i | input | 1 | Channel 2 code-epoch tick |
| sign_o | output | 1 | Registered test sign |
| mag_o | output | 1 | Registered test magnitude |

## Verification
The assertions assume that the epoch tick is a single-cycle pulse sampled on the clock, and that phase and chip inputs are stable between edges. The stimulus changes every input only on the falling clock edge. It pulses the epoch ticks far more often than once per millisecond, so that many 20-tick data periods fit into a short run. The assertions also assume that `src_sel_i` is not changed in the same cycle as an epoch tick it is meant to count. The bench switches the source only in stretches that are checked against a model fed with the same selection.

// File: rtl/stg_pkg.sv
package stg_pkg;
  localparam int PH_W = 5;

  typedef struct packed {
    logic [PH_W-1:0] phase;
    logic            chip;
    logic            epoch;
  } stg_src_t;
endpackage

// File: rtl/stg_src_mux.sv
module stg_src_mux
  import stg_pkg::*;
#(
  parameter int N_SRC = 2,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  stg_src_t           src_i [N_SRC],
  input  logic [SEL_W-1:0]   sel_i,
  output stg_src_t           src_o
);
  always_comb begin
    src_o = src_i[0];
    for (int k = 1; k < N_SRC; k++) begin
      if (sel_i == SEL_W'(k)) src_o = src_i[k];
    end
  end
endmodule

// File: rtl/stg_weight.sv
module stg_weight
  import stg_pkg::*;
(
  input  logic [PH_W-1:0] phase_i,
  output logic            sign_o,
  output logic            mag_o
);
  assign sign_o = phase_i[PH_W-1];

  always_comb begin
    unique casez (phase_i)
      5'b01011,
      5'b011??,
      5'b100??,
      5'b10100: mag_o = 1'b1;
      default:  mag_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/stg_data_bit.sv
module stg_data_bit #(
  parameter int EPOCHS = 20,
  localparam int CNT_W = (EPOCHS > 1) ? $clog2(EPOCHS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic epoch_i,
  output logic data_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      data_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      data_q <= 1'b0;
    end else if (epoch_i) begin
      if (cnt_q == CNT_W'(EPOCHS - 1)) begin
        cnt_q  <= '0;
        data_q <= ~data_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign data_o = data_q;

  // R5
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !epoch_i) |=> $stable(data_q));

  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(EPOCHS));

  // R6
  data_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!data_q && cnt_q == '0));
endmodule

// File: rtl/stg_noise.sv
module stg_noise #(
  parameter int LFSR_W = 15,
  parameter int DUTY_W = 8,
  parameter int TAP_A  = 14,
  parameter int TAP_B  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              noise_o
);
  localparam logic [LFSR_W-1:0] SEED = LFSR_W'(1);

  logic [LFSR_W-1:0] lfsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lfsr_q <= SEED;
    else if (clr_i)  lfsr_q <= SEED;
    else             lfsr_q <= {lfsr_q[LFSR_W-2:0], lfsr_q[TAP_A] ^ lfsr_q[TAP_B]};
  end

  assign noise_o = lfsr_q[DUTY_W-1:0] < duty_i;

  // R7
  lfsr_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);

  // R8
  no_noise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_i == '0) |-> !noise_o);
endmodule

// File: rtl/stg_top.sv
module stg_top
  import stg_pkg::*;
#(
  parameter int EPOCHS_PER_BIT = 20,
  parameter int LFSR_W         = 15,
  parameter int DUTY_W         = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              src_sel_i,
  input  logic              chan_rst_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [PH_W-1:0]   ch1_phase_i,
  input  logic              ch1_chip_i,
  input  logic              ch1_epoch_i,
  input  logic [PH_W-1:0]   ch2_phase_i,
  input  logic              ch2_chip_i,
  input  logic              ch2_epoch_i,
  output logic              sign_o,
  output logic              mag_o
);
  localparam int N_SRC = 2;

  stg_src_t srcs [N_SRC];
  stg_src_t sel_src;
  logic     clr;
  logic     w_sign, w_mag, data_bit, noise_bit;
  logic     sign_q, mag_q;

  assign srcs[0] = '{phase: ch1_phase_i, chip: ch1_chip_i, epoch: ch1_epoch_i};
  assign srcs[1] = '{phase: ch2_phase_i, chip: ch2_chip_i, epoch: ch2_epoch_i};
  assign clr     = !en_i || chan_rst_i;

  stg_src_mux #(.N_SRC(N_SRC)) u_mux (
    .src_i (srcs),
    .sel_i (src_sel_i),
    .src_o (sel_src)
  );

  stg_weight u_weight (
    .phase_i (sel_src.phase),
    .sign_o  (w_sign),
    .mag_o   (w_mag)
  );

  stg_data_bit #(.EPOCHS(EPOCHS_PER_BIT)) u_data (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .epoch_i (sel_src.epoch),
    .data_o  (data_bit)
  );

  stg_noise #(.LFSR_W(LFSR_W), .DUTY_W(DUTY_W)) u_noise (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .duty_i  (duty_i),
    .noise_o (noise_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sign_q <= 1'b0;
      mag_q  <= 1'b0;
    end else if (!en_i) begin
      sign_q <= 1'b0;
      mag_q  <= 1'b0;
    end else begin
      sign_q <= w_sign ^ sel_src.chip ^ data_bit ^ noise_bit;
      mag_q  <= w_mag;
    end
  end

  assign sign_o = sign_q;
  assign mag_o  = mag_q;

  // R1
  off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!sign_o && !mag_o));

  // R3
  mag_band_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mag_o |-> ($past(sel_src.phase[PH_W-1]) != $past(sel_src.phase[PH_W-2])));

  // R9
  mag_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (mag_o == $past(w_mag)));
endmodule

// File: tb/tb_stg_top.sv
module tb_stg_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, src = 1'b0, crst = 1'b0;
  logic [7:0] duty = '0;
  logic [4:0] p1 = '0, p2 = '0;
  logic       c1 = 1'b0, c2 = 1'b0, e1 = 1'b0, e2 = 1'b0;
  logic       sign, mag;

  int checks = 0, fails = 0;
  int m_cnt = 0, m_data = 0, m_lfsr = 1;

  always #2 clk = ~clk;

  stg_top dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .src_sel_i(src), .chan_rst_i(crst),
    .duty_i(duty), .ch1_phase_i(p1), .ch1_chip_i(c1), .ch1_epoch_i(e1),
    .ch2_phase_i(p2), .ch2_chip_i(c2), .ch2_epoch_i(e2),
    .sign_o(sign), .mag_o(mag)
  );

  function automatic int mag_of(int p);
    return (p == 11 || (p >= 12 && p <= 19) || p == 20) ? 1 : 0;
  endfunction

  task automatic check(string tag, int got_s, int got_m, int exp_s, int exp_m);
    checks++;
    if (got_s != exp_s || got_m != exp_m) begin
      fails++;
      $display("FAIL %s: sign/mag got %0d/%0d expected %0d/%0d", tag, got_s, got_m, exp_s, exp_m);
    end
  endtask

  // inputs set at negedge; predict, clock, compare after the edge
  task automatic cycle(string tag);
    int ph, ch, ep, noise, es, em;
    ph = src ? int'(p2) : int'(p1);
    ch = src ? int'(c2) : int'(c1);
    ep = src ? int'(e2) : int'(e1);
    if (!en) begin
      es = 0; em = 0;
    end else begin
      noise = ((m_lfsr % 256) < int'(duty)) ? 1 : 0;
      es = ((ph / 16) ^ ch ^ m_data ^ noise) & 1;
      em = mag_of(ph);
    end
    if (!en || crst) begin
      m_cnt = 0; m_data = 0; m_lfsr = 1;
    end else begin
      if (ep != 0) begin
        if (m_cnt == 19) begin m_cnt = 0; m_data = 1 - m_data; end
        else m_cnt++;
      end
      m_lfsr = ((m_lfsr * 2) + (((m_lfsr / 16384) ^ (m_lfsr / 8192)) & 1)) % 32768;
    end
    @(posedge clk);
    #1;
    check(tag, int'(sign), int'(mag), es, em);
    @(negedge clk);
  endtask

  task automatic rnd_inputs(int epoch_div, int i);
    p1 = 5'($urandom); p2 = 5'($urandom);
    c1 = 1'($urandom); c2 = 1'($urandom);
    e1 = (i % epoch_div) == 0;
    e2 = (i % epoch_div) == 1;
  endtask

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", int'(sign), int'(mag), 0, 0);
    rst_n = 1'b1;

    // R1: disabled, busy inputs
    for (int i = 0; i < 20; i++) begin rnd_inputs(2, i); duty = 8'hff; cycle("R1"); end

    // R3 R4 R5 R9: every phase value, clean signal, channel 1
    en = 1'b1; duty = 8'h00;
    for (int i = 0; i < 400; i++) begin
      rnd_inputs(3, i);
      p1 = 5'(i % 32);
      cycle("R3 R4 R5 R9");
    end

    // R2: channel 2 source, channel 1 random
    src = 1'b1;
    for (int i = 0; i < 300; i++) begin rnd_inputs(2, i); cycle("R2"); end
    src = 1'b0;

    // R6: common channel reset pulses, then enable drop
    for (int i = 0; i < 200; i++) begin
      rnd_inputs(2, i);
      crst = (i % 37) == 36;
      cycle("R6");
    end
    crst = 1'b0;
    en = 1'b0;
    for (int i = 0; i < 5; i++) begin rnd_inputs(2, i); cycle("R1 R6"); end
    en = 1'b1;

    // R7: noise at several duty levels
    duty = 8'h60;
    for (int i = 0; i < 300; i++) begin rnd_inputs(4, i); cycle("R7"); end
    duty = 8'hff;
    for (int i = 0; i < 200; i++) begin rnd_inputs(4, i); cycle("R7"); end
    duty = 8'h01;
    for (int i = 0; i < 200; i++) begin rnd_inputs(4, i); cycle("R7"); end

    // R8: noise off again mid-run
    duty = 8'h00;
    for (int i = 0; i < 200; i++) begin rnd_inputs(2, i); cycle("R8"); end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule